// File: doc/BRIEF.md
# Averaging Engine Control Register File

This block holds the configuration that steers a weighted-averaging packet engine and reports a little of that engine's status. Software reaches it through a plain write/read handshake port on the register clock. A write carries an address, data and an enable. A read carries an address and an enable and returns data one cycle later with a valid strobe. Both directions also report an error flag.

The configuration fields are driven straight out as control outputs:
- an engine enable bit;
- a two-bit operating mode;
- a set of averaging weights;
- a two-bit input-packet masking mode;
- a two-bit packet wait timeout.

The engine's stream clock domain sends two kinds of single-cycle pulses: one when an input packet has been parsed, and one when an output packet has been built. Each kind is carried into the register clock domain by a toggle synchronizer and counted there. An 8-bit sample count taken from the last input packet can also be read.

Widths, the number of weights and the synchronizer depth are parameters. Every register offset is derived from the weight count.

Top module: `avg_ctrl_regs`

## Requirements
- R1: After reset:
  - `eng_enable` is 0 and `eng_mode` is 00 (stop);
  - every weight, `mask_mode`, `wait_timeout` and both event counters are 0;
  - `wr_ready` and `rd_ready` are always 1.
- R2: The address map uses word offsets, and only offsets with address bits [1:0] equal to 00 are mapped:
  - 0x00 is control: bit 0 is the enable and bits [2:1] are the mode, where 00 is stop, 01 is carry fixed data and 10 is solo.
  - 0x04 + 4*(n-1) holds weight kn in bits [15:0], for n = 1..10.
  - 0x2C is masking: bits [1:0] are the masking mode and bits [3:2] are the timeout. Masking mode 0 masks input after one packet until one output packet is sent, 1 never masks, and 3 chooses by a stage-count comparison.
  - 0x30 is the parse count, 0x34 is the build count and 0x38 is the sample count; all three are read-only.
- R3: A write with `wr_en` high to a writable offset updates the addressed field at the next clock edge. Bits outside the field are dropped.
- R4: A write to an unmapped or misaligned address raises `wr_err` in the same cycle as `wr_en` and changes no register.
- R5: A write to a read-only offset raises `wr_err` and leaves the counters and status unchanged.
- R6: `rd_valid` is high for exactly the cycle after a cycle with `rd_en` high. In that cycle `rd_data` holds the addressed value, with unused upper bits reading 0, and `rd_err` is 0 for a mapped address.
- R7: A read of an unmapped or misaligned address returns `rd_err` = 1 and `rd_data` = 0 in its valid cycle.
- R8: Each `parse_done` pulse in the stream domain increments the parse count once. The increment is visible within 6 register clock cycles after the pulse.
  - Pulses must be at least 3 register clock cycles apart.
  - The single-cycle pulse that reaches the counter is isolated.
- R9: Each `build_done` pulse in the stream domain increments the build count once, with the same latency and spacing rule as R8.
- R10: Each event counter is CNT_W bits wide and wraps to 0 after its all-ones value.
- R11: A read of offset 0x38 returns `last_sample_cnt` as sampled at the clock edge that ends the `rd_en` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Register clock |
| cfg_rst_n | input | 1 | Asynchronous active-low reset, register domain |
| strm_clk | input | 1 | Stream clock of the pulse sources |
| strm_rst_n | input | 1 | Asynchronous active-low reset, stream domain |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write data |
| wr_en | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted (constant 1) |
| wr_err | output | 1 | Write rejected: unmapped, misaligned or read-only |
| rd_addr | input | ADDR_W | Read byte address |
| rd_en | input | 1 | Read request |
| rd_ready | output | 1 | Read accepted (constant 1) |
| rd_data | output | DATA_W | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data strobe, one cycle after rd_en |
| rd_err | output | 1 | Read rejected, valid with rd_valid |
| eng_enable | output | 1 | Engine enable |
| eng_mode | output | 2 | Operating mode |
| weights | output | NUM_WEIGHTS*WEIGHT_W | Weights, k1 in the lowest slice |
| mask_mode | output | 2 | Input-packet masking mode |
| wait_timeout | output | 2 | Packet wait timeout |
| parse_done | input | 1 | Parse-complete pulse, stream domain |
| build_done | input | 1 | Build-complete pulse, stream domain |
| last_sample_cnt | input | SAMPLE_W | Sample count of the last packet |

## Verification
Each result has its own timing:
- `wr_err` is combinational and is sampled shortly after the write request is driven, before the clock edge.
- Written fields appear after one edge and are checked at the following falling edge.
- Read results are registered once. The bench drives `rd_en` on a falling edge, lets one rising edge pass, and samples `rd_valid`, `rd_data` and `rd_err` at the next falling edge. It then confirms `rd_valid` has dropped one cycle later.

Counter pulses cross three register-domain flops plus a counter flop. The bench therefore spaces pulses four stream cycles apart and waits eight register cycles before reading the counters. It runs a narrow counter width so that wrap-around can be reached quickly.

// File: rtl/avg_cfg_pkg.sv
package avg_cfg_pkg;

   typedef enum logic [1:0] {
      MODE_STOP  = 2'b00,
      MODE_CARRY = 2'b01,
      MODE_SOLO  = 2'b10,
      MODE_RSVD  = 2'b11
   } eng_mode_e;

   typedef enum logic [2:0] {
      KIND_CTRL   = 3'd0,
      KIND_WEIGHT = 3'd1,
      KIND_MASK   = 3'd2,
      KIND_PCNT   = 3'd3,
      KIND_BCNT   = 3'd4,
      KIND_SAMPLE = 3'd5,
      KIND_NONE   = 3'd7
   } reg_kind_e;

   function automatic logic kind_is_ro(reg_kind_e k);
      return (k == KIND_PCNT) || (k == KIND_BCNT) || (k == KIND_SAMPLE);
   endfunction

endpackage

// File: rtl/avg_reg_decode.sv
module avg_reg_decode
   import avg_cfg_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int NUM_WEIGHTS = 10,
   localparam int WIDX_W     = $clog2(NUM_WEIGHTS)
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_kind_e         kind,
   output logic [WIDX_W-1:0] widx
);
   localparam int WORD_W   = ADDR_W - 2;
   localparam int IDX_MASK = NUM_WEIGHTS + 1;
   localparam int IDX_PCNT = NUM_WEIGHTS + 2;
   localparam int IDX_BCNT = NUM_WEIGHTS + 3;
   localparam int IDX_SMPL = NUM_WEIGHTS + 4;

   logic [WORD_W-1:0] word;
   logic              aligned;
   logic [WORD_W-1:0] wofs;

   assign word    = addr[ADDR_W-1:2];
   assign aligned = (addr[1:0] == 2'b00);
   assign wofs    = word - WORD_W'(1);
   assign widx    = wofs[WIDX_W-1:0];

   always_comb begin
      kind = KIND_NONE;
      if (aligned) begin
         if (word == '0)
            kind = KIND_CTRL;
         else if (word <= WORD_W'(NUM_WEIGHTS))
            kind = KIND_WEIGHT;
         else if (word == WORD_W'(IDX_MASK))
            kind = KIND_MASK;
         else if (word == WORD_W'(IDX_PCNT))
            kind = KIND_PCNT;
         else if (word == WORD_W'(IDX_BCNT))
            kind = KIND_BCNT;
         else if (word == WORD_W'(IDX_SMPL))
            kind = KIND_SAMPLE;
      end
   end

   // R2: a weight hit always carries an index inside the weight set
   always_comb begin
      if (kind == KIND_WEIGHT)
         p_widx_range_r2: assert (int'(widx) < NUM_WEIGHTS);
   end

endmodule

// File: rtl/avg_pulse_sync.sv
module avg_pulse_sync #(
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b0
) (
   input  logic src_clk,
   input  logic src_rst_n,
   input  logic src_pulse,
   input  logic dst_clk,
   input  logic dst_rst_n,
   output logic dst_pulse
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("avg_pulse_sync: SYNC_STAGES must be at least 2");
   end

   logic                   src_toggle;
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   edge_seen;

   always_ff @(posedge src_clk or negedge src_rst_n) begin
      if (!src_rst_n)
         src_toggle <= 1'b0;
      else if (src_pulse)
         src_toggle <= ~src_toggle;
   end

   always_ff @(posedge dst_clk or negedge dst_rst_n) begin
      if (!dst_rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], src_toggle};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign edge_seen = sync_q[SYNC_STAGES-1] ^ last_q;

   if (OUT_REG) begin : g_reg_out
      logic pulse_q;
      always_ff @(posedge dst_clk or negedge dst_rst_n) begin
         if (!dst_rst_n)
            pulse_q <= 1'b0;
         else
            pulse_q <= edge_seen;
      end
      assign dst_pulse = pulse_q;
   end else begin : g_comb_out
      assign dst_pulse = edge_seen;
   end

   // R8: with the required spacing a crossed event lasts a single cycle
   p_pulse_isolated_r8: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
      dst_pulse |=> !dst_pulse);

endmodule

// File: rtl/avg_event_counter.sv
module avg_event_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   if (CNT_W < 1) begin : g_bad_width
      $error("avg_event_counter: CNT_W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (inc)
         count <= count + CNT_W'(1);
   end

   // R10: one step per event, wrapping from all-ones to zero
   p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      inc |=> count == $past(count) + CNT_W'(1));
   // R5: nothing but an event moves the count
   p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(count));

endmodule

// File: rtl/avg_ctrl_regs.sv
module avg_ctrl_regs
   import avg_cfg_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int NUM_WEIGHTS = 10,
   parameter int WEIGHT_W    = 16,
   parameter int CNT_W       = 16,
   parameter int SAMPLE_W    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                            cfg_clk,
   input  logic                            cfg_rst_n,
   input  logic                            strm_clk,
   input  logic                            strm_rst_n,
   input  logic [ADDR_W-1:0]               wr_addr,
   input  logic [DATA_W-1:0]               wr_data,
   input  logic                            wr_en,
   output logic                            wr_ready,
   output logic                            wr_err,
   input  logic [ADDR_W-1:0]               rd_addr,
   input  logic                            rd_en,
   output logic                            rd_ready,
   output logic [DATA_W-1:0]               rd_data,
   output logic                            rd_valid,
   output logic                            rd_err,
   output logic                            eng_enable,
   output logic [1:0]                      eng_mode,
   output logic [NUM_WEIGHTS*WEIGHT_W-1:0] weights,
   output logic [1:0]                      mask_mode,
   output logic [1:0]                      wait_timeout,
   input  logic                            parse_done,
   input  logic                            build_done,
   input  logic [SAMPLE_W-1:0]             last_sample_cnt
);
   localparam int WIDX_W = $clog2(NUM_WEIGHTS);

   if (NUM_WEIGHTS < 2)         begin : g_bad_nw  $error("NUM_WEIGHTS must be at least 2"); end
   if (WEIGHT_W > DATA_W)       begin : g_bad_ww  $error("WEIGHT_W exceeds DATA_W"); end
   if (CNT_W > DATA_W)          begin : g_bad_cw  $error("CNT_W exceeds DATA_W"); end
   if (SAMPLE_W > DATA_W)       begin : g_bad_sw  $error("SAMPLE_W exceeds DATA_W"); end
   if (DATA_W < 4)              begin : g_bad_dw  $error("DATA_W too narrow for the fields"); end
   if (ADDR_W < 8)              begin : g_bad_aw  $error("ADDR_W too narrow for the map"); end

   // ---------------- decode
   reg_kind_e         wr_kind, rd_kind;
   logic [WIDX_W-1:0] wr_widx, rd_widx;

   avg_reg_decode #(.ADDR_W(ADDR_W), .NUM_WEIGHTS(NUM_WEIGHTS)) u_wr_dec (
      .addr(wr_addr), .kind(wr_kind), .widx(wr_widx));
   avg_reg_decode #(.ADDR_W(ADDR_W), .NUM_WEIGHTS(NUM_WEIGHTS)) u_rd_dec (
      .addr(rd_addr), .kind(rd_kind), .widx(rd_widx));

   assign wr_ready = 1'b1;
   assign rd_ready = 1'b1;

   logic wr_bad;
   logic wr_ok;
   assign wr_bad = (wr_kind == KIND_NONE) || kind_is_ro(wr_kind);
   assign wr_err = wr_en && wr_bad;
   assign wr_ok  = wr_en && !wr_bad;

   // ---------------- configuration registers
   always_ff @(posedge cfg_clk or negedge cfg_rst_n) begin
      if (!cfg_rst_n) begin
         eng_enable <= 1'b0;
         eng_mode   <= MODE_STOP;
      end else if (wr_ok && wr_kind == KIND_CTRL) begin
         eng_enable <= wr_data[0];
         eng_mode   <= wr_data[2:1];
      end
   end

   always_ff @(posedge cfg_clk or negedge cfg_rst_n) begin
      if (!cfg_rst_n) begin
         mask_mode    <= 2'b00;
         wait_timeout <= 2'b00;
      end else if (wr_ok && wr_kind == KIND_MASK) begin
         mask_mode    <= wr_data[1:0];
         wait_timeout <= wr_data[3:2];
      end
   end

   logic [WEIGHT_W-1:0] weight_q [NUM_WEIGHTS];

   for (genvar i = 0; i < NUM_WEIGHTS; i++) begin : g_weight
      always_ff @(posedge cfg_clk or negedge cfg_rst_n) begin
         if (!cfg_rst_n)
            weight_q[i] <= '0;
         else if (wr_ok && wr_kind == KIND_WEIGHT && wr_widx == WIDX_W'(i))
            weight_q[i] <= wr_data[WEIGHT_W-1:0];
      end
      assign weights[i*WEIGHT_W +: WEIGHT_W] = weight_q[i];
   end

   // ---------------- event counters fed across the clock boundary
   logic             parse_evt, build_evt;
   logic [CNT_W-1:0] parse_cnt, build_cnt;

   avg_pulse_sync #(.SYNC_STAGES(SYNC_STAGES), .OUT_REG(1'b0)) u_parse_sync (
      .src_clk(strm_clk), .src_rst_n(strm_rst_n), .src_pulse(parse_done),
      .dst_clk(cfg_clk), .dst_rst_n(cfg_rst_n), .dst_pulse(parse_evt));
   avg_pulse_sync #(.SYNC_STAGES(SYNC_STAGES), .OUT_REG(1'b0)) u_build_sync (
      .src_clk(strm_clk), .src_rst_n(strm_rst_n), .src_pulse(build_done),
      .dst_clk(cfg_clk), .dst_rst_n(cfg_rst_n), .dst_pulse(build_evt));

   avg_event_counter #(.CNT_W(CNT_W)) u_parse_cnt (
      .clk(cfg_clk), .rst_n(cfg_rst_n), .inc(parse_evt), .count(parse_cnt));
   avg_event_counter #(.CNT_W(CNT_W)) u_build_cnt (
      .clk(cfg_clk), .rst_n(cfg_rst_n), .inc(build_evt), .count(build_cnt));

   // ---------------- read path
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      unique case (rd_kind)
         KIND_CTRL:   rd_mux = DATA_W'({eng_mode, eng_enable});
         KIND_MASK:   rd_mux = DATA_W'({wait_timeout, mask_mode});
         KIND_PCNT:   rd_mux = DATA_W'(parse_cnt);
         KIND_BCNT:   rd_mux = DATA_W'(build_cnt);
         KIND_SAMPLE: rd_mux = DATA_W'(last_sample_cnt);
         KIND_WEIGHT: begin
            for (int i = 0; i < NUM_WEIGHTS; i++)
               if (rd_widx == WIDX_W'(i))
                  rd_mux = DATA_W'(weight_q[i]);
         end
         default:     rd_mux = '0;
      endcase
   end

   always_ff @(posedge cfg_clk or negedge cfg_rst_n) begin
      if (!cfg_rst_n) begin
         rd_valid <= 1'b0;
         rd_err   <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_en;
         rd_err   <= rd_en && (rd_kind == KIND_NONE);
         if (rd_en)
            rd_data <= rd_mux;
      end
   end

   // ---------------- properties
   p_rd_valid_r6: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
      rd_en |=> rd_valid);
   p_rd_idle_r6: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
      !rd_en |=> !rd_valid);
   p_rd_err_zero_r7: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
      (rd_valid && rd_err) |-> rd_data == '0);
   p_bad_wr_hold_r4: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
      (wr_en && wr_err) |=> ($stable(eng_enable) && $stable(eng_mode) &&
                             $stable(mask_mode) && $stable(wait_timeout) &&
                             $stable(weights)));
   p_mode_write_r3: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
      (wr_en && !wr_err && wr_addr == '0) |=>
         (eng_mode == $past(wr_data[2:1]) && eng_enable == $past(wr_data[0])));

endmodule

// File: tb/test_avg_ctrl_regs.sv
`timescale 1ns/1ps
module test_avg_ctrl_regs;
   localparam int AW = 32, DW = 32, NW = 10, WW = 16, CW = 4, SW = 8;

   logic cfg_clk = 1'b0, strm_clk = 1'b0;
   logic cfg_rst_n = 1'b0, strm_rst_n = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic wr_ready, wr_err, rd_ready, rd_valid, rd_err;
   logic [DW-1:0] rd_data;
   logic eng_enable;
   logic [1:0] eng_mode, mask_mode, wait_timeout;
   logic [NW*WW-1:0] weights;
   logic parse_done = 1'b0, build_done = 1'b0;
   logic [SW-1:0] last_sample_cnt = '0;

   int n_checks = 0, n_fail = 0;
   bit finished = 0;
   int parse_exp = 0, build_exp = 0;

   always #2.5 cfg_clk = ~cfg_clk;
   always #3.5 strm_clk = ~strm_clk;

   avg_ctrl_regs #(.ADDR_W(AW), .DATA_W(DW), .NUM_WEIGHTS(NW), .WEIGHT_W(WW),
                   .CNT_W(CW), .SAMPLE_W(SW), .SYNC_STAGES(2)) i_avg_ctrl_regs (
      .cfg_clk, .cfg_rst_n, .strm_clk, .strm_rst_n,
      .wr_addr, .wr_data, .wr_en, .wr_ready, .wr_err,
      .rd_addr, .rd_en, .rd_ready, .rd_data, .rd_valid, .rd_err,
      .eng_enable, .eng_mode, .weights, .mask_mode, .wait_timeout,
      .parse_done, .build_done, .last_sample_cnt);

   task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d, logic exp_err, string req);
      @(negedge cfg_clk);
      wr_addr = a; wr_data = d; wr_en = 1'b1;
      #1 chk(req, {31'd0, wr_err}, {31'd0, exp_err});
      @(negedge cfg_clk);
      wr_en = 1'b0;
   endtask

   task automatic do_read(logic [AW-1:0] a, output logic [DW-1:0] d, output logic e);
      @(negedge cfg_clk);
      rd_addr = a; rd_en = 1'b1;
      @(negedge cfg_clk);
      rd_en = 1'b0;
      chk("R6 valid", {31'd0, rd_valid}, 32'd1);
      d = rd_data; e = rd_err;
      @(negedge cfg_clk);
      chk("R6 valid drop", {31'd0, rd_valid}, 32'd0);
   endtask

   task automatic read_expect(logic [AW-1:0] a, logic [DW-1:0] exp_d, logic exp_e, string req);
      logic [DW-1:0] d; logic e;
      do_read(a, d, e);
      chk(req, d, exp_d);
      chk(req, {31'd0, e}, {31'd0, exp_e});
   endtask

   task automatic pulse_events(int np, int nb);
      for (int k = 0; k < ((np > nb) ? np : nb); k++) begin
         @(negedge strm_clk);
         parse_done = (k < np); build_done = (k < nb);
         @(negedge strm_clk);
         parse_done = 1'b0; build_done = 1'b0;
         repeat (3) @(negedge strm_clk);
      end
      parse_exp = (parse_exp + np) % (1 << CW);
      build_exp = (build_exp + nb) % (1 << CW);
      repeat (8) @(negedge cfg_clk);
   endtask

   task automatic t_reset;
      @(negedge cfg_clk);
      chk("R1 enable", {31'd0, eng_enable}, 32'd0);
      chk("R1 mode", {30'd0, eng_mode}, 32'd0);
      chk("R1 weights", {31'd0, |weights}, 32'd0);
      chk("R1 mask", {28'd0, wait_timeout, mask_mode}, 32'd0);
      chk("R1 ready", {30'd0, wr_ready, rd_ready}, 32'd3);
      read_expect(32'h30, 32'd0, 1'b0, "R1 parse count");
      read_expect(32'h34, 32'd0, 1'b0, "R1 build count");
   endtask

   task automatic t_ctrl;
      do_write(32'h00, 32'h5, 1'b0, "R3 ctrl werr");
      chk("R3 enable", {31'd0, eng_enable}, 32'd1);
      chk("R3 mode solo", {30'd0, eng_mode}, 32'd2);
      read_expect(32'h00, 32'h5, 1'b0, "R6 ctrl read");
      do_write(32'h00, 32'hFFFF_FFF3, 1'b0, "R3 ctrl werr2");
      chk("R3 mode carry", {30'd0, eng_mode}, 32'd1);
      read_expect(32'h00, 32'h3, 1'b0, "R6 ctrl upper bits zero");
   endtask

   task automatic t_weights;
      for (int i = 0; i < NW; i++)
         do_write(32'h04 + 4*i, 32'hABCD_0000 | (32'h1000 + i*32'h111), 1'b0, "R3 weight werr");
      for (int i = 0; i < NW; i++) begin
         chk("R3 weight out", {16'd0, weights[i*WW +: WW]}, 32'h1000 + i*32'h111);
         read_expect(32'h04 + 4*i, 32'h1000 + i*32'h111, 1'b0, "R2 weight read");
      end
   endtask

   task automatic t_mask;
      do_write(32'h2C, 32'hE, 1'b0, "R3 mask werr");
      chk("R2 mask field", {30'd0, mask_mode}, 32'd2);
      chk("R2 timeout field", {30'd0, wait_timeout}, 32'd3);
      read_expect(32'h2C, 32'hE, 1'b0, "R2 mask read");
   endtask

   task automatic t_bad_addr;
      do_write(32'h3C, 32'h0, 1'b1, "R4 werr 0x3C");
      do_write(32'h02, 32'h0, 1'b1, "R4 werr misaligned");
      do_write(32'h1000_0000, 32'h0, 1'b1, "R4 werr high");
      do_write(32'h1000_0004, 32'h0, 1'b1, "R4 werr alias");
      chk("R4 ctrl kept", {29'd0, eng_mode, eng_enable}, 32'h3);
      chk("R4 weight kept", {16'd0, weights[0 +: WW]}, 32'h1000);
      chk("R4 mask kept", {28'd0, wait_timeout, mask_mode}, 32'hE);
      read_expect(32'h3C, 32'd0, 1'b1, "R7 read 0x3C");
      read_expect(32'h05, 32'd0, 1'b1, "R7 read misaligned");
   endtask

   task automatic t_counters;
      pulse_events(3, 5);
      read_expect(32'h30, parse_exp, 1'b0, "R8 parse count");
      read_expect(32'h34, build_exp, 1'b0, "R9 build count");
      do_write(32'h30, 32'h7, 1'b1, "R5 werr parse");
      do_write(32'h34, 32'h7, 1'b1, "R5 werr build");
      do_write(32'h38, 32'h7, 1'b1, "R5 werr sample");
      read_expect(32'h30, parse_exp, 1'b0, "R5 parse kept");
      read_expect(32'h34, build_exp, 1'b0, "R5 build kept");
      pulse_events(15, 0);
      read_expect(32'h30, parse_exp, 1'b0, "R10 parse wrap");
      read_expect(32'h34, build_exp, 1'b0, "R10 build steady");
   endtask

   task automatic t_sample;
      last_sample_cnt = 8'hA7;
      read_expect(32'h38, 32'hA7, 1'b0, "R11 sample");
      last_sample_cnt = 8'h3C;
      read_expect(32'h38, 32'h3C, 1'b0, "R11 sample update");
   endtask

   initial begin
      repeat (3) @(negedge cfg_clk);
      cfg_rst_n = 1'b1; strm_rst_n = 1'b1;
      t_reset;
      t_ctrl;
      t_weights;
      t_mask;
      t_bad_addr;
      t_counters;
      t_sample;
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge cfg_clk);
      if (!finished) begin
         finished = 1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule